// File: doc/BRIEF.md
# Receive Frame Buffer with Rollback

This block holds the bytes of incoming radio frames in a shared circular store of 128 bytes. A demodulator pushes bytes in as a valid/ready stream, framed by a pulse when the frame delimiter has been received and a pulse when the frame is complete. A host drains the store through a show-ahead pop stream. Any number of frames may be resident at once, as long as their total size fits in the store.

The buffer knows where frames begin. When the address filter outside the block rejects the frame in progress, the buffer discards that frame's bytes in one cycle. It does this by restoring a write pointer captured at the frame's delimiter, and bytes of earlier frames are left untouched. A byte offered while the store is full puts the buffer into a sticky overflow state. The state is shown by the pair "data available low, frame ready high". New input stays blocked until a flush command is given. A flush that comes before the host has read anything since the overflow leaves the frame-ready flag high until the host next attempts a pop.

Input back-pressure rules: `in_ready` is high only while a frame is open and no overflow is pending. The radio cannot stall, so a byte offered with `in_ready` high while the store is full is dropped and starts the overflow. Output rules: `out_valid` is high while any byte is stored, `out_data` shows the oldest byte, and a pop happens on a cycle with `out_valid` and `out_ready` both high.

Top module: `rx_frame_buffer`

## Requirements
- R1: The store holds at most 128 bytes. Once 128 bytes are stored, a further accepted byte is not stored and sets the overflow state at the next clock edge.
- R2: `sof_ind` goes high on the clock edge that samples `delim_done`, and it stays high while the frame's bytes arrive.
- R3: On a frame that is not rejected, `sof_ind` goes low on the edge that samples `frame_end`, which arrives with or after the last byte.
- R4: On the edge that samples `addr_reject`, `sof_ind` goes low and every byte of the open frame is removed. Bytes of frames completed earlier stay in place and are read out in order.
- R5: `data_avail` goes high on the edge that writes a frame's first byte (its length field). It stays high while any byte remains, including bytes of earlier frames, and goes low when the store becomes empty.
- R6: `frame_ready` is high when the stored byte count is strictly greater than `thresh`, or when at least one byte of a completed frame is still stored.
- R7: While the overflow state is set, `data_avail` is low and `frame_ready` is high. Bytes already stored keep their values and can still be popped.
- R8: While the overflow state is set, `in_ready` is low and no byte is written, until a flush.
- R9: `flush` empties the store, closes any open frame and clears the overflow state at the next edge. If no pop attempt was made since the overflow began, `frame_ready` stays high until the next edge that samples `out_ready` high.
- R10: While the store is empty, `out_valid` is low and `out_data` is 0. Asserting `out_ready` then does not move the read position.
- R11: Outside an open frame, `in_ready` is low and offered bytes are not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| delim_done | input | 1 | Pulse: frame delimiter fully received, opens a frame |
| in_valid | input | 1 | Input byte offered |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Input byte will be taken (frame open, no overflow) |
| frame_end | input | 1 | Pulse: last byte of the frame has arrived |
| addr_reject | input | 1 | Pulse: open frame failed address filtering |
| flush | input | 1 | Pulse: empty the store and clear overflow |
| thresh | input | 7 | Byte-count threshold for `frame_ready` |
| out_valid | output | 1 | A stored byte is available |
| out_data | output | 8 | Oldest stored byte, 0 when empty |
| out_ready | input | 1 | Pop request / read attempt |
| sof_ind | output | 1 | Frame in progress indicator |
| data_avail | output | 1 | Store non-empty and no overflow |
| frame_ready | output | 1 | Threshold passed, complete frame stored, or overflow |

## Verification
All state changes on the clock edge that samples the stimulus. `sof_ind`, the count, the pointers and the overflow state are registers, and every status output is decoded from them without further delay, so each result is due one edge after its stimulus. The bench drives inputs just after a falling edge. It removes pulses and checks at the next falling edge, which is half a period after the edge that took effect. Popped data is compared before the edge that consumes it, because the output is show-ahead.

// File: rtl/rxfb_pkg.sv
package rxfb_pkg;
  typedef logic [7:0] rxfb_byte_t;
endpackage

// File: rtl/rxfb_mem.sv
module rxfb_mem #(
  parameter int unsigned DEPTH = 128,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic                 clk,
  input  logic                 we,
  input  logic [AW-1:0]        waddr,
  input  rxfb_pkg::rxfb_byte_t wdata,
  input  logic [AW-1:0]        raddr,
  output rxfb_pkg::rxfb_byte_t rdata
);
  rxfb_pkg::rxfb_byte_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/rxfb_wctl.sv
module rxfb_wctl #(
  parameter int unsigned DEPTH = 128,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          delim_done,
  input  logic          in_valid,
  input  logic          frame_end,
  input  logic          addr_reject,
  input  logic          flush,
  input  logic          pop_req,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] rd_addr,
  output logic [CW-1:0] count,
  output logic          committed,
  output logic          ovf,
  output logic          sof,
  output logic          in_ready,
  output logic          out_valid
);
  // Pointers carry one extra wrap bit so that full and empty differ.
  logic [CW-1:0] wr_q, rd_q, snap_q, cp_q;
  logic [CW-1:0] wr_nxt, rd_nxt, frame_len, remain;
  logic          in_frame_q, full, pop_do, wr_try, ovf_set;

  assign count     = wr_q - rd_q;
  assign full      = (count == CW'(DEPTH));
  assign out_valid = (count != '0);
  assign in_ready  = in_frame_q && !ovf;
  assign committed = (cp_q != rd_q);
  assign pop_do    = pop_req && out_valid;
  assign wr_try    = in_valid && in_ready && !addr_reject && !flush;
  assign wr_en     = wr_try && !full;
  assign ovf_set   = wr_try && full;
  assign wr_nxt    = wr_q + CW'(wr_en);
  assign rd_nxt    = rd_q + CW'(pop_do);
  assign frame_len = wr_q - snap_q;
  assign remain    = wr_q - rd_nxt;
  assign wr_addr   = wr_q[AW-1:0];
  assign rd_addr   = rd_q[AW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= '0; rd_q <= '0; snap_q <= '0; cp_q <= '0;
      in_frame_q <= 1'b0; sof <= 1'b0; ovf <= 1'b0;
    end else if (flush) begin
      wr_q <= '0; rd_q <= '0; snap_q <= '0; cp_q <= '0;
      in_frame_q <= 1'b0; sof <= 1'b0; ovf <= 1'b0;
    end else begin
      rd_q <= rd_nxt;
      if (ovf_set) ovf <= 1'b1;
      // Commit pointer never trails the read pointer.
      if (cp_q == rd_q && pop_do) cp_q <= rd_nxt;
      if (addr_reject) begin
        in_frame_q <= 1'b0;
        sof        <= 1'b0;
        if (!ovf) begin
          if (remain >= frame_len) wr_q <= snap_q;
          else                     wr_q <= rd_nxt;
        end
      end else if (frame_end) begin
        in_frame_q <= 1'b0;
        sof        <= 1'b0;
        wr_q       <= wr_nxt;
        if (!ovf && !ovf_set) cp_q <= wr_nxt;
      end else if (delim_done) begin
        in_frame_q <= 1'b1;
        sof        <= 1'b1;
        wr_q       <= wr_nxt;
        snap_q     <= wr_nxt;
      end else begin
        wr_q <= wr_nxt;
      end
    end
  end
endmodule

// File: rtl/rxfb_flags.sv
module rxfb_flags #(
  parameter int unsigned DEPTH = 128,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] count,
  input  logic          committed,
  input  logic          ovf,
  input  logic          flush,
  input  logic          pop_req,
  input  logic [AW-1:0] thresh,
  output logic          data_avail,
  output logic          frame_ready
);
  logic popped_q, hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      popped_q <= 1'b0;
      hold_q   <= 1'b0;
    end else begin
      popped_q <= ovf && (popped_q || pop_req);
      if (pop_req)                      hold_q <= 1'b0;
      else if (flush && ovf && !popped_q) hold_q <= 1'b1;
    end
  end

  assign data_avail  = (count != '0) && !ovf;
  assign frame_ready = hold_q || ovf || committed || (count > {1'b0, thresh});
endmodule

// File: rtl/rx_frame_buffer.sv
module rx_frame_buffer #(
  parameter int unsigned DEPTH = 128,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          delim_done,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  output logic          in_ready,
  input  logic          frame_end,
  input  logic          addr_reject,
  input  logic          flush,
  input  logic [AW-1:0] thresh,
  output logic          out_valid,
  output logic [7:0]    out_data,
  input  logic          out_ready,
  output logic          sof_ind,
  output logic          data_avail,
  output logic          frame_ready
);
  logic          wr_en, committed, ovf;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [CW-1:0] count;
  rxfb_pkg::rxfb_byte_t rd_byte;

  rxfb_wctl #(.DEPTH(DEPTH)) u_wctl (
    .clk(clk), .rst_n(rst_n), .delim_done(delim_done), .in_valid(in_valid),
    .frame_end(frame_end), .addr_reject(addr_reject), .flush(flush),
    .pop_req(out_ready), .wr_en(wr_en), .wr_addr(wr_addr), .rd_addr(rd_addr),
    .count(count), .committed(committed), .ovf(ovf), .sof(sof_ind),
    .in_ready(in_ready), .out_valid(out_valid)
  );

  rxfb_mem #(.DEPTH(DEPTH)) u_mem (
    .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(in_data),
    .raddr(rd_addr), .rdata(rd_byte)
  );

  rxfb_flags #(.DEPTH(DEPTH)) u_flags (
    .clk(clk), .rst_n(rst_n), .count(count), .committed(committed), .ovf(ovf),
    .flush(flush), .pop_req(out_ready), .thresh(thresh),
    .data_avail(data_avail), .frame_ready(frame_ready)
  );

  assign out_data = out_valid ? rd_byte : 8'h00;
endmodule

// File: rtl/rxfb_checker.sv
module rxfb_checker #(
  parameter int unsigned DEPTH = 128,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = AW + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          delim_done,
  input logic          in_valid,
  input logic          frame_end,
  input logic          addr_reject,
  input logic          flush,
  input logic          in_ready,
  input logic          out_valid,
  input logic [7:0]    out_data,
  input logic          sof_ind,
  input logic          data_avail,
  input logic          frame_ready,
  input logic [CW-1:0] count,
  input logic          ovf
);
  a_r1_cap_limit: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  a_r2_sof_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (delim_done && !addr_reject && !frame_end && !flush) |=> sof_ind);
  a_r3_sof_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && !delim_done) |=> !sof_ind);
  a_r4_reject_fall: assert property (@(posedge clk) disable iff (!rst_n)
    addr_reject |=> !sof_ind);
  a_r5_avail_valid: assert property (@(posedge clk) disable iff (!rst_n)
    data_avail |-> out_valid);
  a_r7_ovf_flags: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> (frame_ready && !data_avail));
  a_r8_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !flush) |=> (count <= $past(count)));
  a_r8_no_ready: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> !in_ready);
  a_r9_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!out_valid && !sof_ind && !ovf));
  a_r10_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (out_data == 8'h00));
  a_r11_closed: assert property (@(posedge clk) disable iff (!rst_n)
    (!sof_ind && in_valid && !delim_done && !flush) |=> (count <= $past(count)));
endmodule

bind rx_frame_buffer rxfb_checker #(.DEPTH(DEPTH)) i_rxfb_checker (
  .clk(clk), .rst_n(rst_n), .delim_done(delim_done), .in_valid(in_valid),
  .frame_end(frame_end), .addr_reject(addr_reject), .flush(flush),
  .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
  .sof_ind(sof_ind), .data_avail(data_avail), .frame_ready(frame_ready),
  .count(count), .ovf(ovf)
);

// File: tb/test_rx_frame_buffer.sv
module test_rx_frame_buffer;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       delim_done = 1'b0, in_valid = 1'b0, frame_end = 1'b0;
  logic       addr_reject = 1'b0, flush = 1'b0, out_ready = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic [6:0] thresh = 7'd127;
  logic       in_ready, out_valid, sof_ind, data_avail, frame_ready;
  logic [7:0] out_data;
  int         n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_frame_buffer i_rx_frame_buffer (
    .clk(clk), .rst_n(rst_n), .delim_done(delim_done), .in_valid(in_valid),
    .in_data(in_data), .in_ready(in_ready), .frame_end(frame_end),
    .addr_reject(addr_reject), .flush(flush), .thresh(thresh),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
    .sof_ind(sof_ind), .data_avail(data_avail), .frame_ready(frame_ready)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic open_frame();
    delim_done = 1'b1; cyc(); delim_done = 1'b0;
  endtask

  task automatic push(input logic [7:0] b);
    in_valid = 1'b1; in_data = b; cyc(); in_valid = 1'b0;
  endtask

  task automatic close_frame();
    frame_end = 1'b1; cyc(); frame_end = 1'b0;
  endtask

  task automatic reject();
    addr_reject = 1'b1; cyc(); addr_reject = 1'b0;
  endtask

  task automatic do_flush();
    flush = 1'b1; cyc(); flush = 1'b0;
  endtask

  task automatic pop_exp(input string req, input logic [7:0] exp);
    chk({req, " valid"}, 32'(out_valid), 32'd1);
    chk({req, " data"}, 32'(out_data), 32'(exp));
    out_ready = 1'b1; cyc(); out_ready = 1'b0;
  endtask

  task automatic t_reset();
    chk("R5 reset avail", 32'(data_avail), 0);
    chk("R6 reset ready", 32'(frame_ready), 0);
    chk("R2 reset sof", 32'(sof_ind), 0);
    chk("R10 reset valid", 32'(out_valid), 0);
    chk("R11 reset in_ready", 32'(in_ready), 0);
  endtask

  task automatic t_closed_input();
    push(8'hEE);
    chk("R11 byte ignored outside frame", 32'(out_valid), 0);
  endtask

  task automatic t_single_frame();
    open_frame();
    chk("R2 sof high", 32'(sof_ind), 1);
    chk("R11 in_ready open", 32'(in_ready), 1);
    chk("R5 avail before length", 32'(data_avail), 0);
    push(8'h03);
    chk("R5 avail after length", 32'(data_avail), 1);
    push(8'hA1); push(8'hA2); push(8'hA3);
    chk("R2 sof held", 32'(sof_ind), 1);
    chk("R6 ready low before end", 32'(frame_ready), 0);
    close_frame();
    chk("R3 sof low", 32'(sof_ind), 0);
    chk("R6 ready complete frame", 32'(frame_ready), 1);
    pop_exp("R5 pop", 8'h03); pop_exp("R5 pop", 8'hA1);
    pop_exp("R5 pop", 8'hA2);
    chk("R5 avail one left", 32'(data_avail), 1);
    pop_exp("R5 pop", 8'hA3);
    chk("R5 avail empty", 32'(data_avail), 0);
    chk("R6 ready after drain", 32'(frame_ready), 0);
  endtask

  task automatic t_reject();
    open_frame(); push(8'h11); push(8'h22); close_frame();
    open_frame(); push(8'h33); push(8'h44); push(8'h55);
    reject();
    chk("R4 sof low", 32'(sof_ind), 0);
    chk("R4 earlier frame ready", 32'(frame_ready), 1);
    pop_exp("R4 kept", 8'h11); pop_exp("R4 kept", 8'h22);
    chk("R4 rejected bytes gone", 32'(out_valid), 0);
    chk("R6 ready after drain", 32'(frame_ready), 0);
  endtask

  task automatic t_threshold();
    thresh = 7'd2;
    open_frame(); push(8'h01); push(8'h02);
    chk("R6 count equal thresh", 32'(frame_ready), 0);
    push(8'h03);
    chk("R6 count above thresh", 32'(frame_ready), 1);
    reject();
    chk("R4 all removed", 32'(out_valid), 0);
    thresh = 7'd127;
  endtask

  task automatic t_empty_pop();
    chk("R10 empty data zero", 32'(out_data), 0);
    out_ready = 1'b1; cyc(); cyc(); out_ready = 1'b0;
    chk("R10 still empty", 32'(out_valid), 0);
    open_frame(); push(8'h7C); close_frame();
    pop_exp("R10 pointer unmoved", 8'h7C);
  endtask

  task automatic fill_full();
    open_frame();
    for (int i = 0; i < 128; i++) push(8'(i) ^ 8'h5A);
  endtask

  task automatic t_overflow_read();
    fill_full();
    chk("R1 full not overflowed", 32'(data_avail), 1);
    chk("R1 in_ready at full", 32'(in_ready), 1);
    push(8'hFF);
    chk("R7 avail low", 32'(data_avail), 0);
    chk("R7 ready high", 32'(frame_ready), 1);
    chk("R8 in_ready low", 32'(in_ready), 0);
    push(8'hFE);
    pop_exp("R7 stored intact", 8'h5A);
    pop_exp("R7 stored intact", 8'h5B);
    do_flush();
    chk("R9 empty", 32'(out_valid), 0);
    chk("R9 ready low after read", 32'(frame_ready), 0);
    chk("R9 frame closed", 32'(in_ready), 0);
  endtask

  task automatic t_overflow_noread();
    fill_full(); push(8'hFF);
    do_flush();
    chk("R9 empty", 32'(out_valid), 0);
    chk("R9 ready held", 32'(frame_ready), 1);
    cyc();
    chk("R9 ready still held", 32'(frame_ready), 1);
    out_ready = 1'b1; cyc(); out_ready = 1'b0;
    chk("R9 ready cleared by read", 32'(frame_ready), 0);
    open_frame(); push(8'h42); close_frame();
    pop_exp("R9 accepts after flush", 8'h42);
  endtask

  initial begin
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();
    t_reset();
    t_closed_input();
    t_single_frame();
    t_reject();
    t_threshold();
    t_empty_pop();
    t_overflow_read();
    t_overflow_noread();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule